// File: doc/BRIEF.md
# Single-Cycle Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. The core handles nine instructions: word load and store, five register-to-register operations (add, subtract, and, or, set-on-less-than), branch-if-equal and an unconditional jump. Fetch, decode, operand read, execution, memory access and register write-back all happen within one clock period. There is no multi-step sequencing.

The core drives a program counter to an instruction memory. That memory returns the instruction word combinationally. It also drives an address, write data and strobes to a separate data memory, which returns load data in the same cycle. Neither memory port has a handshake. Both memories must answer within the cycle, so neither can apply back-pressure. Register-file write activity is brought out on dedicated pins so that an environment can follow the architectural effect of each instruction. Reset is synchronous and active-high.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0. While `rst` is high, `rf_we` and `dmem_we` stay low.
- R2: For every instruction that is not a taken branch or a jump, the PC advances by 4 at each edge. The PC is always word aligned.
- R3: An R-type instruction has opcode 0x00 in bits 31:26, rs in bits 25:21, rt in bits 20:16, rd in bits 15:11 and funct in bits 5:0. Funct 0x20 writes rs+rt, 0x22 writes rs-rt, 0x24 writes rs AND rt and 0x25 writes rs OR rt into register rd. Arithmetic wraps modulo 2^32 with no trap.
- R4: Funct 0x2A (set-on-less-than) writes 1 to rd when rs is less than rt as signed two's-complement numbers, and 0 otherwise.
- R5: Load (opcode 0x23) presents rs plus the sign-extended bits 15:0 on `dmem_addr` with `dmem_re` high. It writes `dmem_rdata` into register rt.
- R6: Store (opcode 0x2B) presents rs plus the sign-extended bits 15:0 on `dmem_addr`, presents rt on `dmem_wdata` and raises `dmem_we`. It does not write the register file. In any cycle, at most one of load, store, branch and jump is decoded.
- R7: Branch (opcode 0x04) compares rs and rt. If they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2. Otherwise the next PC is PC+4. A branch writes nothing.
- R8: Jump (opcode 0x02) sets the next PC to the upper 4 bits of PC+4 followed by bits 25:0 shifted left by 2. A jump writes nothing.
- R9: Register 0 always reads as zero. A write aimed at register 0 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc | output | 32 | Current PC, used as the instruction fetch address |
| imem_data | input | 32 | Instruction word at `pc`, valid in the same cycle |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the next rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, valid in the same cycle |
| rf_we | output | 1 | Register-file write strobe for this cycle |
| rf_waddr | output | 5 | Destination register index |
| rf_wdata | output | 32 | Value being written to the register file |

## Verification
The program mixes loads of positive, negative and mixed-bit words with each arithmetic and logic function. A sign-unaware comparator would get set-on-less-than wrong between -3 and 5, and a swapped destination select would write rs or rt in place of rd. A store goes through a base register with a negative offset, so an immediate that is zero-extended rather than sign-extended lands far from the intended address. The same negative offset also catches a subtraction placed where the address adder should be. The program then runs a branch that is not taken, a forward taken branch, a jump, and a branch back onto itself. A dropped zero-flag test, a missing shift of the offset, or a jump that loses the upper PC bits would each send fetch to the wrong word. An add aimed at register 0, followed by a read of register 0, shows whether a core keeps the discarded value.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [5:0] {
    OPC_REG   = 6'h00,
    OPC_JUMP  = 6'h02,
    OPC_BEQ   = 6'h04,
    OPC_LOAD  = 6'h23,
    OPC_STORE = 6'h2B
  } opcode_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // class of ALU work requested by the main decoder
  typedef enum logic [1:0] {
    AOP_ADD   = 2'd0,
    AOP_SUB   = 2'd1,
    AOP_FUNCT = 2'd2
  } alu_class_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic       dst_is_rd;
    logic       b_is_imm;
    logic       wb_from_mem;
    logic       reg_we;
    logic       mem_re;
    logic       mem_we;
    logic       branch;
    logic       jump;
    alu_class_e alu_class;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_fn_e    alu_fn
);

  // main decoder: opcode to datapath selects and strobes
  always_comb begin
    ctrl = '0;
    ctrl.alu_class = AOP_ADD;
    case (opcode)
      OPC_REG: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = 1'b1;
        ctrl.alu_class = AOP_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_we      = 1'b1;
        ctrl.mem_re      = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch    = 1'b1;
        ctrl.alu_class = AOP_SUB;
      end
      OPC_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  // ALU decoder: class plus funct to ALU function
  always_comb begin
    case (ctrl.alu_class)
      AOP_SUB:   alu_fn = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_SLT:  alu_fn = ALU_SLT;
          default: alu_fn = ALU_ADD;
        endcase
      end
      default:   alu_fn = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     ra1,
  input  logic [AW-1:0]     ra2,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2
);

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) store_q[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : store_q[ra1];
  assign rd2 = (ra2 == '0) ? '0 : store_q[ra2];

  // R9: the hard-wired zero register is never seen as non-zero
  p_r0_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ((ra1 == '0) |-> (rd1 == '0)) and ((ra2 == '0) |-> (rd2 == '0)));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (fn)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_COUNT = 32,
  localparam int RA_W     = $clog2(REG_COUNT),
  localparam int IMM_W    = 16,
  localparam int TGT_W    = 26
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] pc,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            rf_we,
  output logic [RA_W-1:0] rf_waddr,
  output logic [XLEN-1:0] rf_wdata
);

  logic [XLEN-1:0] pc_q, pc_plus4, br_target, jmp_target, pc_next;
  logic [XLEN-1:0] imm_ext, src_a, src_b, rt_val, alu_y;
  logic            alu_zero, take_branch;
  logic [RA_W-1:0] f_rs, f_rt, f_rd;
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;

  assign f_rs    = imem_data[25:21];
  assign f_rt    = imem_data[20:16];
  assign f_rd    = imem_data[15:11];
  assign imm_ext = {{(XLEN-IMM_W){imem_data[IMM_W-1]}}, imem_data[IMM_W-1:0]};

  sc_decode u_dec (
    .opcode (imem_data[31:26]),
    .funct  (imem_data[5:0]),
    .ctrl   (ctrl),
    .alu_fn (alu_fn)
  );

  sc_regfile #(.DATA_W(XLEN), .DEPTH(REG_COUNT)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra1   (f_rs),
    .ra2   (f_rt),
    .rd1   (src_a),
    .rd2   (rt_val)
  );

  assign src_b = ctrl.b_is_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (src_a),
    .b    (src_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // write-back and memory side
  assign rf_we      = ctrl.reg_we & ~rst;
  assign rf_waddr   = ctrl.dst_is_rd ? f_rd : f_rt;
  assign rf_wdata   = ctrl.wb_from_mem ? dmem_rdata : alu_y;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we & ~rst;
  assign dmem_re    = ctrl.mem_re & ~rst;

  // next-PC logic with its own adders
  assign pc_plus4    = pc_q + XLEN'(4);
  assign br_target   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_target  = {pc_plus4[XLEN-1 -: 4], imem_data[TGT_W-1:0], 2'b00};
  assign take_branch = ctrl.branch & alu_zero;

  always_comb begin
    if (ctrl.jump)        pc_next = jmp_target;
    else if (take_branch) pc_next = br_target;
    else                  pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc = pc_q;

  // R1: no architectural write escapes while reset is held
  p_quiet_reset_r1: assert property (@(posedge clk)
    rst |-> (!rf_we && !dmem_we));

  // R2: fetch address stays word aligned
  p_pc_align_r2: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

  // R2: straight-line instructions step the PC by one word
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl.jump) && !$past(take_branch))
      |-> (pc_q == $past(pc_q) + XLEN'(4)));

  // R6: memory, branch and jump roles never overlap
  p_ctrl_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.mem_re, ctrl.mem_we, ctrl.branch, ctrl.jump}));

  // R6: a store never also writes the register file
  p_no_dual_write_r6: assert property (@(posedge clk) disable iff (rst)
    !(rf_we && dmem_we));

  // R7: a taken branch lands on the offset target
  p_branch_taken_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(take_branch)) |-> (pc_q == $past(br_target)));

  // R8: a jump keeps the top nibble of the incremented PC
  p_jump_upper_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.jump))
      |-> (pc_q[XLEN-1 -: 4] == $past(pc_plus4[XLEN-1 -: 4])));

endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc, imem_data, dmem_addr, dmem_wdata, dmem_rdata, rf_wdata;
  logic        dmem_we, dmem_re, rf_we;
  logic [4:0]  rf_waddr;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] m_dm [64];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;
  string       pc_tag = "R2";

  always #5 clk = ~clk;

  sc_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .pc         (pc),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_re    (dmem_re),
    .dmem_rdata (dmem_rdata),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata)
  );

  assign imem_data  = imem[pc[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference step: evaluate the instruction at m_pc, compare, then commit
  task automatic step_check();
    logic [31:0] ins, a, b, se, res, nxt;
    logic [5:0]  op, fn;
    int          rs, rt, rd;
    string       tag;
    ins = imem[m_pc[7:2]];
    op  = ins[31:26]; fn = ins[5:0];
    rs  = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a   = (rs == 0) ? 32'd0 : m_rf[rs];
    b   = (rt == 0) ? 32'd0 : m_rf[rt];
    se  = {{16{ins[15]}}, ins[15:0]};
    nxt = m_pc + 32'd4;
    check(pc_tag, "pc", pc, m_pc);
    pc_tag = "R2";
    case (op)
      6'h00: begin
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          default: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
        tag = (fn == 6'h2A) ? "R4" : "R3";
        if (rs == 0 || rd == 0) tag = "R9";
        check(tag, "rf_we", {31'd0, rf_we}, 32'd1);
        check(tag, "rf_waddr", {27'd0, rf_waddr}, 32'(rd));
        check(tag, "rf_wdata", rf_wdata, res);
        check(tag, "dmem_we", {31'd0, dmem_we}, 32'd0);
        if (rd != 0) m_rf[rd] = res;
      end
      6'h23: begin
        res = m_dm[(a + se) >> 2 & 32'h3F];
        check("R5", "dmem_addr", dmem_addr, a + se);
        check("R5", "dmem_re", {31'd0, dmem_re}, 32'd1);
        check("R5", "rf_waddr", {27'd0, rf_waddr}, 32'(rt));
        check("R5", "rf_wdata", rf_wdata, res);
        if (rt != 0) m_rf[rt] = res;
      end
      6'h2B: begin
        check("R6", "dmem_we", {31'd0, dmem_we}, 32'd1);
        check("R6", "dmem_addr", dmem_addr, a + se);
        check("R6", "dmem_wdata", dmem_wdata, b);
        check("R6", "rf_we", {31'd0, rf_we}, 32'd0);
        m_dm[(a + se) >> 2 & 32'h3F] = b;
      end
      6'h04: begin
        check("R7", "writes", {30'd0, rf_we, dmem_we}, 32'd0);
        if (a == b) begin
          nxt = m_pc + 32'd4 + (se << 2);
          pc_tag = "R7";
        end
      end
      default: begin
        check("R8", "writes", {30'd0, rf_we, dmem_we}, 32'd0);
        nxt = {nxt[31:28], ins[25:0], 2'b00};
        pc_tag = "R8";
      end
    endcase
    m_pc = nxt;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'd0; dmem[i] = 32'd0;
    end
    dmem[1] = 32'd5;
    dmem[2] = 32'hFFFF_FFFD;
    dmem[3] = 32'h0F0F_00FF;
    dmem[4] = 32'h0000_0040;
    for (int i = 0; i < 64; i++) m_dm[i] = dmem[i];
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    imem[0]  = enc_i(6'h23, 0, 1, 16'd4);
    imem[1]  = enc_i(6'h23, 0, 2, 16'd8);
    imem[2]  = enc_i(6'h23, 0, 3, 16'd12);
    imem[3]  = enc_r(1, 2, 4, 6'h20);
    imem[4]  = enc_r(1, 2, 5, 6'h22);
    imem[5]  = enc_r(3, 1, 6, 6'h24);
    imem[6]  = enc_r(3, 2, 7, 6'h25);
    imem[7]  = enc_r(2, 1, 8, 6'h2A);
    imem[8]  = enc_r(1, 2, 9, 6'h2A);
    imem[9]  = enc_r(1, 1, 0, 6'h20);
    imem[10] = enc_r(0, 0, 10, 6'h20);
    imem[11] = enc_i(6'h2B, 0, 4, 16'd32);
    imem[12] = enc_i(6'h23, 0, 11, 16'd32);
    imem[13] = enc_i(6'h23, 0, 12, 16'd16);
    imem[14] = enc_i(6'h2B, 12, 5, 16'hFFF8);
    imem[15] = enc_i(6'h23, 0, 13, 16'h0038);
    imem[16] = enc_i(6'h04, 1, 2, 16'd5);
    imem[17] = enc_i(6'h04, 1, 1, 16'd2);
    imem[18] = enc_r(1, 1, 14, 6'h20);
    imem[19] = enc_r(1, 1, 14, 6'h20);
    imem[20] = enc_j(26'd23);
    imem[21] = enc_r(1, 1, 16, 6'h20);
    imem[22] = enc_r(1, 1, 16, 6'h20);
    imem[23] = enc_i(6'h04, 0, 0, 16'd1);
    imem[24] = enc_r(1, 1, 17, 6'h20);
    imem[25] = enc_r(13, 11, 15, 6'h20);
    imem[26] = enc_i(6'h04, 0, 0, 16'hFFFF);

    rst = 1'b1;
    m_pc = 32'd0;
    @(posedge clk);
    repeat (2) begin
      @(negedge clk);
      check("R1", "pc", pc, 32'd0);
      check("R1", "writes", {30'd0, rf_we, dmem_we}, 32'd0);
    end
    rst = 1'b0;
    for (int c = 0; c < 40; c++) begin
      #1 step_check();
      @(negedge clk);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule